// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers interrupt requests from two places: level-sensitive hardware lines and single-cycle software interrupt pulses that carry an interrupt number. Each request has a numeric level. When the core signals an instruction boundary, the controller chooses one request that is pending and not masked, and delivers it. The lowest level number wins. A delivery comes with a handler address formed from a programmable base and the level. It also tells the core to enter kernel mode.

Each delivered level is pushed onto a small in-service stack, together with the mode the core was in when the interrupt was taken. While a level is on top of that stack, only requests with a strictly lower number can pre-empt it. When the handler finishes, it raises an end-of-interrupt strobe. The controller then pops the top entry and reports the mode the core must return to. The masking that applied before the nested interrupt is restored at the same time. The stack has a fixed depth. If an interrupt is chosen while the stack is full, the interrupt is held back and a sticky error flag is set.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_take`, `irq_return`, `in_service` and `nest_overflow` are 0, and no software request is pending.
- R2: On a delivery, `irq_vector` equals the `vec_base` value that was present at the boundary cycle plus four times `irq_level`. For level 0x80 (system call) this is base + 0x200.
- R3: When several requests are eligible at the same boundary, the one with the lowest level number is delivered.
- R4: A delivery happens only in the cycle after a clock edge at which `insn_boundary` was 1. Pending requests wait, with no delivery, while the strobe is low.
- R5: While level i is on top of the in-service stack, requests at levels j >= i are not delivered. Requests at levels below i are delivered, and they nest.
- R6: A one-cycle `sw_req` pulse with `sw_num` = n makes level n pending. It stays pending until it is delivered, and delivery clears it. The pulse becomes eligible from the next edge onward.
- R7: External line k drives level k through a two-flop synchroniser. A line must have been high at two edges before the boundary edge for it to be seen. A line is not latched: if it is dropped before it is delivered, nothing is delivered.
- R8: `eoi` with a non-empty stack pops the top entry and pulses `irq_return` for one cycle. On that pulse, `ret_user` equals the `core_user` value that was sampled when the popped level was taken. `eoi` with an empty stack has no effect.
- R9: If a delivery would exceed `STACK_DEPTH` nested levels, nothing is delivered and the request stays pending. `nest_overflow` is then set and remains set until reset.
- R10: `in_service` is 1 exactly while the stack is non-empty. `active_level` shows the level on top of the stack, and right after a delivery it equals `irq_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | NUM_EXT | Level-sensitive hardware request lines; line k is level k |
| sw_req | input | 1 | Software interrupt pulse |
| sw_num | input | LVL_W (8) | Level requested by the software interrupt |
| insn_boundary | input | 1 | Instruction-boundary strobe from the core |
| core_user | input | 1 | Core is currently in user mode |
| vec_base | input | ADDR_W | Handler table base address |
| eoi | input | 1 | End-of-interrupt strobe from the handler |
| irq_take | output | 1 | One-cycle delivery pulse; core enters kernel mode |
| irq_level | output | LVL_W | Delivered level |
| irq_vector | output | ADDR_W | Handler address of the delivered level |
| irq_return | output | 1 | One-cycle pulse when an end-of-interrupt pops the stack |
| ret_user | output | 1 | Mode to restore on that return (1 = user) |
| in_service | output | 1 | At least one level is in service |
| active_level | output | LVL_W | Level on top of the in-service stack |
| nest_overflow | output | 1 | Sticky nesting-overflow flag |

## Verification
Every one of the 256 software levels and every one of the 32 hardware lines is delivered with a changing base. A vector adder that drops the scale of four, or loses the upper level bits, would therefore give a wrong address. Every pair of levels drawn from the lowest sixteen is injected at the same time. A priority picker that favours the higher number, or a mask that compares with `>` instead of `>=`, would deliver the wrong one first, or would re-deliver a level while it is still in service.

A nest that is four levels deep, with the mode alternating at each level, checks two things. A stack that pops in the wrong order would return the wrong mode. A stack that lets a fifth entry in would corrupt the unwind. The synchroniser is also probed: a line that is taken one edge too early shows that a flop is missing.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    // Width of an interrupt level number; the level space is 2**LVL_W.
    localparam int LVL_W = 8;

    // One entry of the in-service stack.
    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             was_user;
    } isr_frame_t;

endpackage

// File: rtl/ivc_sync.sv
module ivc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ivc_lowest_pick.sv
module ivc_lowest_pick #(
    parameter int N = 256,
    parameter int W = 8
) (
    input  logic [N-1:0] req_i,
    output logic         found_o,
    output logic [W-1:0] idx_o
);

    always_comb begin
        found_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = W'(i);
            end
        end
    end

endmodule

// File: rtl/ivc_level_stack.sv
module ivc_level_stack
    import ivc_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  isr_frame_t       push_frame_i,
    input  logic             pop_i,
    output isr_frame_t       top_frame_o,
    output logic [LVL_W-1:0] next_level_o,
    output logic [CNT_W-1:0] count_o
);

    isr_frame_t       frames_q [DEPTH];
    isr_frame_t       frames_d [DEPTH];
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_mid;

    always_comb begin
        frames_d = frames_q;
        cnt_mid  = cnt_q;
        if (pop_i && cnt_q != '0) begin
            cnt_mid = cnt_q - 1'b1;
        end
        cnt_d = cnt_mid;
        if (push_i && cnt_mid < CNT_W'(DEPTH)) begin
            frames_d[IDX_W'(cnt_mid)] = push_frame_i;
            cnt_d = cnt_mid + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                frames_q[e] <= '0;
            end
        end else begin
            cnt_q    <= cnt_d;
            frames_q <= frames_d;
        end
    end

    always_comb begin
        top_frame_o  = '0;
        next_level_o = '0;
        if (cnt_q != '0) begin
            top_frame_o = frames_q[IDX_W'(cnt_q - 1'b1)];
        end
        if (cnt_q > CNT_W'(1)) begin
            next_level_o = frames_q[IDX_W'(cnt_q - CNT_W'(2))].level;
        end
    end

    assign count_o = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)); // R9

    AST_NESTS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && cnt_q != '0 && cnt_q < CNT_W'(DEPTH))
            |-> (push_frame_i.level < top_frame_o.level)); // R5

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter  int NUM_EXT     = 32,
    parameter  int ADDR_W      = 32,
    parameter  int STACK_DEPTH = 4,
    localparam int NLEV        = 1 << LVL_W,
    localparam int CNT_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic               sw_req,
    input  logic [LVL_W-1:0]   sw_num,
    input  logic               insn_boundary,
    input  logic               core_user,
    input  logic [ADDR_W-1:0]  vec_base,
    input  logic               eoi,
    output logic               irq_take,
    output logic [LVL_W-1:0]   irq_level,
    output logic [ADDR_W-1:0]  irq_vector,
    output logic               irq_return,
    output logic               ret_user,
    output logic               in_service,
    output logic [LVL_W-1:0]   active_level,
    output logic               nest_overflow
);

    typedef struct packed {
        logic [NLEV-1:0]   sw_pend;
        logic              take;
        logic [LVL_W-1:0]  level;
        logic [ADDR_W-1:0] vector;
        logic              ret;
        logic              ret_user;
        logic              err;
    } ctrl_state_t;

    ctrl_state_t state_q, state_d;

    logic [NUM_EXT-1:0] ext_s;
    logic [NLEV-1:0]    pend, elig;
    logic               pick_found;
    logic [LVL_W-1:0]   pick_idx;
    isr_frame_t         top_frame, push_frame;
    logic [LVL_W-1:0]   next_level, mask_lvl;
    logic [CNT_W-1:0]   depth, depth_mid;
    logic               pop_ok, have_mask, room, want, take;

    ivc_sync #(
        .WIDTH  (NUM_EXT),
        .STAGES (2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_irq),
        .sync_o  (ext_s)
    );

    assign pend = state_q.sw_pend | NLEV'(ext_s);

    // Mask uses the stack as it will be after this cycle's pop.
    assign pop_ok    = eoi && (depth != '0);
    assign depth_mid = depth - CNT_W'(pop_ok);
    assign have_mask = (depth_mid != '0);
    assign mask_lvl  = pop_ok ? next_level : top_frame.level;

    for (genvar g = 0; g < NLEV; g++) begin : g_elig
        assign elig[g] = pend[g] && (!have_mask || (LVL_W'(g) < mask_lvl));
    end

    ivc_lowest_pick #(
        .N (NLEV),
        .W (LVL_W)
    ) u_pick (
        .req_i   (elig),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    assign room = depth_mid < CNT_W'(STACK_DEPTH);
    assign want = insn_boundary && pick_found;
    assign take = want && room;

    assign push_frame = '{level: pick_idx, was_user: core_user};

    ivc_level_stack #(
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (take),
        .push_frame_i (push_frame),
        .pop_i        (pop_ok),
        .top_frame_o  (top_frame),
        .next_level_o (next_level),
        .count_o      (depth)
    );

    always_comb begin
        state_d          = state_q;
        state_d.take     = take;
        state_d.ret      = pop_ok;
        state_d.ret_user = pop_ok ? top_frame.was_user : 1'b0;
        if (take) begin
            state_d.level   = pick_idx;
            state_d.vector  = vec_base + ADDR_W'({pick_idx, 2'b00});
            state_d.sw_pend = state_d.sw_pend & ~(NLEV'(1) << pick_idx);
        end
        if (sw_req) begin
            state_d.sw_pend = state_d.sw_pend | (NLEV'(1) << sw_num);
        end
        if (want && !room) begin
            state_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_take      = state_q.take;
    assign irq_level     = state_q.level;
    assign irq_vector    = state_q.vector;
    assign irq_return    = state_q.ret;
    assign ret_user      = state_q.ret_user;
    assign nest_overflow = state_q.err;
    assign in_service    = (depth != '0);
    assign active_level  = top_frame.level;

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(insn_boundary)); // R4

    AST_VECTOR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_vector - $past(vec_base)) == ADDR_W'({irq_level, 2'b00})); // R2

    AST_TAKE_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (in_service && active_level == irq_level)); // R10

    AST_RET_NEEDS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_return |-> $past(in_service)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(nest_overflow) |-> nest_overflow); // R9

endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_EXT    = 32;
    localparam int WATCHDOG   = 150000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_EXT-1:0] ext_irq = '0;
    logic               sw_req = 1'b0;
    logic [7:0]         sw_num = '0;
    logic               insn_boundary = 1'b0;
    logic               core_user = 1'b0;
    logic [31:0]        vec_base = 32'h0000_4000;
    logic               eoi = 1'b0;
    logic               irq_take, irq_return, ret_user, in_service, nest_overflow;
    logic [7:0]         irq_level, active_level;
    logic [31:0]        irq_vector;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vector_ctrl #(
        .NUM_EXT     (NUM_EXT),
        .ADDR_W      (32),
        .STACK_DEPTH (4)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_irq       (ext_irq),
        .sw_req        (sw_req),
        .sw_num        (sw_num),
        .insn_boundary (insn_boundary),
        .core_user     (core_user),
        .vec_base      (vec_base),
        .eoi           (eoi),
        .irq_take      (irq_take),
        .irq_level     (irq_level),
        .irq_vector    (irq_vector),
        .irq_return    (irq_return),
        .ret_user      (ret_user),
        .in_service    (in_service),
        .active_level  (active_level),
        .nest_overflow (nest_overflow)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc();
        cyc();
        rst_n = 1'b1;
    endtask

    task automatic pulse_sw(input int n);
        sw_req = 1'b1;
        sw_num = 8'(n);
        cyc();
        sw_req = 1'b0;
    endtask

    task automatic boundary();
        insn_boundary = 1'b1;
        cyc();
        insn_boundary = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1;
        cyc();
        eoi = 1'b0;
    endtask

    task automatic expect_take(input int lvl, input string req);
        logic [31:0] exp_vec;
        exp_vec = vec_base + 32'(lvl) * 32'd4;
        chk(irq_take === 1'b1, {req, " take"}, 32'(irq_take), 1);
        chk(irq_level === 8'(lvl), {req, " level"}, 32'(irq_level), 32'(lvl));
        chk(irq_vector === exp_vec, {req, " vector R2"}, irq_vector, exp_vec);
    endtask

    task automatic expect_none(input string req);
        chk(irq_take === 1'b0, {req, " no take"}, 32'(irq_take), 0);
    endtask

    task automatic expect_ret(input bit mode, input string req);
        chk(irq_return === 1'b1, {req, " return"}, 32'(irq_return), 1);
        chk(ret_user === mode, {req, " ret_user"}, 32'(ret_user), 32'(mode));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        cyc();
        // R1: reset state
        chk(irq_take === 1'b0, "R1 take", 32'(irq_take), 0);
        chk(irq_return === 1'b0, "R1 return", 32'(irq_return), 0);
        chk(in_service === 1'b0, "R1 in_service", 32'(in_service), 0);
        chk(nest_overflow === 1'b0, "R1 overflow", 32'(nest_overflow), 0);
        boundary();
        expect_none("R1 nothing pending");

        // R8: eoi with empty stack is ignored
        do_eoi();
        chk(irq_return === 1'b0, "R8 empty eoi", 32'(irq_return), 0);
        chk(in_service === 1'b0, "R8 empty eoi service", 32'(in_service), 0);

        // R2 R6 R10 R8: sweep every software level
        for (int n = 0; n < 256; n++) begin
            vec_base  = 32'h8000_0000 ^ (32'(n) << 12);
            core_user = n[0];
            pulse_sw(n);
            boundary();
            expect_take(n, "R6 sweep");
            chk(in_service === 1'b1 && active_level === 8'(n), "R10 active", 32'(active_level), 32'(n));
            boundary();
            expect_none("R6 cleared after take");
            do_eoi();
            expect_ret(n[0], "R8 sweep");
            chk(in_service === 1'b0, "R10 idle after eoi", 32'(in_service), 0);
        end

        // R2: system-call entry
        vec_base = 32'h0001_0000;
        pulse_sw(8'h80);
        boundary();
        chk(irq_vector === 32'h0001_0200, "R2 syscall vector", irq_vector, 32'h0001_0200);
        do_eoi();

        // R4: pending request waits for the strobe
        pulse_sw(40);
        for (int k = 0; k < 3; k++) begin
            cyc();
            expect_none("R4 no strobe");
        end
        boundary();
        expect_take(40, "R4 strobe");
        do_eoi();

        // R3 R5: every pair among the lowest sixteen levels
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                int lo, hi;
                lo = (a < b) ? a : b;
                hi = (a < b) ? b : a;
                vec_base = 32'h0000_1000 + 32'(a) * 32'h100;
                pulse_sw(a);
                pulse_sw(b);
                boundary();
                expect_take(lo, "R3 pair");
                boundary();
                expect_none("R5 pair masked");
                do_eoi();
                if (a != b) begin
                    boundary();
                    expect_take(hi, "R3 pair second");
                    do_eoi();
                end
            end
        end

        // R5: masking and nesting
        pulse_sw(10);
        boundary();
        expect_take(10, "R5 first");
        pulse_sw(10);
        pulse_sw(12);
        boundary();
        expect_none("R5 equal and higher masked");
        pulse_sw(9);
        boundary();
        expect_take(9, "R5 lower nests");
        do_eoi();
        boundary();
        expect_none("R5 outer mask restored");
        do_eoi();
        boundary();
        expect_take(10, "R5 after unwind");
        do_eoi();
        boundary();
        expect_take(12, "R5 last");
        do_eoi();

        // R7: hardware lines through the synchroniser
        vec_base = 32'h0002_0000;
        ext_irq = 32'(1) << 28;
        cyc();
        boundary();
        expect_none("R7 too early");
        boundary();
        expect_take(28, "R7 clock tick line");
        ext_irq = '0;
        cyc();
        cyc();
        do_eoi();
        ext_irq = 32'(1) << 5;
        cyc();
        ext_irq = '0;
        cyc();
        cyc();
        cyc();
        boundary();
        expect_none("R7 not latched");
        for (int k = 0; k < NUM_EXT; k++) begin
            vec_base  = 32'h0100_0000 + 32'(k) * 32'h40;
            core_user = ~k[0];
            ext_irq   = 32'(1) << k;
            cyc();
            cyc();
            boundary();
            expect_take(k, "R7 sweep");
            ext_irq = '0;
            cyc();
            cyc();
            do_eoi();
            expect_ret(~k[0], "R8 line");
        end

        // R9 R8: nest to full depth, then overflow
        vec_base = 32'h0000_0000;
        for (int d = 0; d < 4; d++) begin
            core_user = (d % 2 == 0);
            pulse_sw(20 - 5 * d);
            boundary();
            expect_take(20 - 5 * d, "R9 nest");
        end
        pulse_sw(3);
        boundary();
        expect_none("R9 stack full");
        chk(nest_overflow === 1'b1, "R9 flag set", 32'(nest_overflow), 1);
        for (int d = 3; d >= 0; d--) begin
            do_eoi();
            expect_ret(d % 2 == 0, "R8 unwind order");
        end
        chk(in_service === 1'b0, "R10 empty after unwind", 32'(in_service), 0);
        chk(nest_overflow === 1'b1, "R9 sticky", 32'(nest_overflow), 1);
        boundary();
        expect_take(3, "R9 held request");
        do_eoi();
        do_reset();
        cyc();
        chk(nest_overflow === 1'b0, "R9 cleared by reset", 32'(nest_overflow), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule